// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a register-programmed SPI master. It moves 8-bit frames out on a serial data output and in on a serial data input, with a serial clock made from the system clock by a programmable divider. Software configures the block through one control word. It queues bytes to send by writing a transmit data register, and it collects received bytes by reading a receive data register.

The control word sets five things. The first is whether the data registers sit in front of two 8-entry queues or act as one-byte buffers. The second is the shift order. The third is whether chip select is driven by the hardware during transfers or held at a level that software programs. The fourth is which of the two interrupt lines may assert. The fifth is the clock half-period. In one-byte buffer mode, two request lines let a DMA engine refill the transmit buffer and drain the receive buffer. In queue mode those lines stay low.

A status word reports the queue states, the transfer-complete condition and a sticky receive-overrun flag. Writing a 1 to the flag's position clears it.

Top module: `spim_ctl`

## Requirements
- R1: With queue mode on (control bit 0 = 1), up to 8 written bytes are held and sent back to back without gaps. Up to 8 received bytes are held, and status bit 3 (receive full) reads 1 when 8 are waiting.
- R2: With queue mode off, each data register holds one byte. A transmit write while the transmit buffer is occupied (status bit 1 = 1) is dropped and never sent.
- R3: The DMA transmit request is high exactly when queue mode is off and the transmit buffer is empty. The DMA receive request is high exactly when queue mode is off and a received byte is waiting. Both are low in queue mode.
- R4: Control bit 1 selects the shift order. 0 sends and receives the most significant bit first, and 1 sends and receives the least significant bit first.
- R5: With control bit 2 = 0, chip select goes low one half-period before the first rising clock edge of a transfer. It stays low across back-to-back frames and returns high one half-period after the last falling edge, so each burst produces exactly one rising edge of chip select.
- R6: With control bit 2 = 1, chip select follows control bit 3 at all times, with or without a transfer running.
- R7: The transfer-complete interrupt is high exactly when control bit 4 = 1, the shifter is idle and the transmit side is empty. Status bit 4 shows the same condition without the enable.
- R8: A frame that completes while the receive side is full is discarded and sets the sticky overrun flag (status bit 5). The flag stays set until a status write with bit 5 = 1 clears it. The overrun interrupt is the flag gated by control bit 5.
- R9: The serial clock idles low and each half-period lasts (control bits 15:8) + 1 system clocks, so consecutive rising edges within a burst are 2 × (divider + 1) clocks apart. Output data changes only while the clock is low.
- R10: After reset the control word is zero, the serial clock is low, chip select is high, both interrupts are low, the DMA transmit request is high, the DMA receive request is low and the status word reads 0x15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive side when addressing receive data |
| bus_addr | input | 2 | Register select: 0 control, 1 transmit data, 2 receive data, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select |
| miso | input | 1 | Serial data in |
| irq_tc | output | 1 | Transfer-complete interrupt |
| irq_ovr | output | 1 | Receive-overrun interrupt |
| dreq_tx | output | 1 | DMA transmit request |
| dreq_rx | output | 1 | DMA receive request |

## Verification
The embedded properties assume that software leaves the control word alone while a frame is on the wire. In particular, the bit-order selection must hold, because the output bit is picked by an index that depends on it. The bench therefore rewrites the control word only after it has polled the status word and seen the transfer-complete condition. It also changes the serial input only just after a rising serial clock edge, so the sampled bit is always settled. Queue fills and overruns are provoked only by writes and unread frames, never by a mid-frame change of mode.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
    localparam int FRAME_W = 8;
    localparam int BC_W    = $clog2(FRAME_W);
    localparam int REG_W   = 16;
    localparam int DIV_W   = 8;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_TXD  = 2'd1,
        A_RXD  = 2'd2,
        A_STAT = 2'd3
    } addr_e;

    typedef struct packed {
        logic [DIV_W-1:0] half_div;
        logic [1:0]       spare;
        logic             ovr_ie;
        logic             tc_ie;
        logic             cs_level;
        logic             cs_manual;
        logic             lsb_first;
        logic             fifo_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL
    } eng_st_e;

    // Position inside the frame of the n-th bit on the wire
    function automatic logic [BC_W-1:0] bit_slot(input logic lsb, input logic [BC_W-1:0] n);
        return lsb ? n : (BC_W'(FRAME_W - 1) - n);
    endfunction
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    // Capacity is DEPTH in queue mode and 1 in single-buffer mode
    assign full    = (cnt >= cap);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R2: a write into an occupied store without a pop leaves the fill unchanged
    a_r2_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (cnt == $past(cnt)));

    // R1: the fill level never exceeds the physical depth
    a_r1_depth_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine
    import spim_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DIV_W-1:0]   half_div,
    input  logic               lsb_first,
    input  logic               cs_manual,
    input  logic               cs_level,
    input  logic               tx_avail,
    input  logic [FRAME_W-1:0] tx_byte,
    output logic               tx_take,
    output logic               rx_valid,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               busy,
    output logic               sck,
    output logic               mosi,
    output logic               cs_n,
    input  logic               miso
);
    eng_st_e            st;
    logic [DIV_W-1:0]   hcnt;
    logic [BC_W-1:0]    bitn;
    logic [FRAME_W-1:0] sh, rxb;
    logic               sck_q;
    logic               hdone, last;

    assign hdone    = (hcnt == half_div);
    assign last     = (bitn == BC_W'(FRAME_W - 1));
    assign rx_valid = (st == ST_HIGH) && hdone && last;
    assign tx_take  = tx_avail && ((st == ST_IDLE) || rx_valid);
    assign rx_byte  = rxb;
    assign busy     = (st != ST_IDLE);
    assign sck      = sck_q;
    assign mosi     = sh[bit_slot(lsb_first, bitn)];
    assign cs_n     = cs_manual ? cs_level : !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            hcnt  <= '0;
            bitn  <= '0;
            sh    <= '0;
            rxb   <= '0;
            sck_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    sck_q <= 1'b0;
                    hcnt  <= '0;
                    if (tx_avail) begin
                        sh   <= tx_byte;
                        bitn <= '0;
                        st   <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (hdone) begin
                        hcnt  <= '0;
                        sck_q <= 1'b1;
                        rxb[bit_slot(lsb_first, bitn)] <= miso;
                        st    <= ST_HIGH;
                    end else begin
                        hcnt <= hcnt + DIV_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (hdone) begin
                        hcnt  <= '0;
                        sck_q <= 1'b0;
                        if (last) begin
                            if (tx_avail) begin
                                sh   <= tx_byte;
                                bitn <= '0;
                                st   <= ST_LOW;
                            end else begin
                                st <= ST_TRAIL;
                            end
                        end else begin
                            bitn <= bitn + BC_W'(1);
                            st   <= ST_LOW;
                        end
                    end else begin
                        hcnt <= hcnt + DIV_W'(1);
                    end
                end
                default: begin
                    if (hdone) begin
                        hcnt <= '0;
                        st   <= ST_IDLE;
                    end else begin
                        hcnt <= hcnt + DIV_W'(1);
                    end
                end
            endcase
        end
    end

    // R9: the serial clock is low whenever the shifter is idle
    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sck_q);

    // R9: output data holds through every high phase
    a_r9_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (sck_q && $past(sck_q)) |-> $stable(mosi));
endmodule

// File: rtl/spim_ctl.sv
`timescale 1ns/1ps
module spim_ctl
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             sck,
    output logic             mosi,
    output logic             cs_n,
    input  logic             miso,
    output logic             irq_tc,
    output logic             irq_ovr,
    output logic             dreq_tx,
    output logic             dreq_rx
);
    ctrl_t              ctrl;
    logic               ovr_q, ovr_clr;
    logic [CW-1:0]      cap;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic [FRAME_W-1:0] tx_head, rx_head, rx_byte;
    logic               tx_take, rx_valid, busy, tc;

    assign cap     = ctrl.fifo_en ? CW'(FIFO_DEPTH) : CW'(1);
    assign ovr_clr = bus_wr && (bus_addr == A_STAT) && bus_wdata[5];
    assign tc      = !busy && tx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (bus_wr && (bus_addr == A_CTRL)) ctrl <= ctrl_t'(bus_wdata);
            if (rx_valid && rx_full)            ovr_q <= 1'b1;
            else if (ovr_clr)                   ovr_q <= 1'b0;
        end
    end

    spim_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .push  (bus_wr && (bus_addr == A_TXD)),
        .din   (bus_wdata[FRAME_W-1:0]),
        .pop   (tx_take),
        .dout  (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spim_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .push  (rx_valid),
        .din   (rx_byte),
        .pop   (bus_rd && (bus_addr == A_RXD)),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spim_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .half_div  (ctrl.half_div),
        .lsb_first (ctrl.lsb_first),
        .cs_manual (ctrl.cs_manual),
        .cs_level  (ctrl.cs_level),
        .tx_avail  (!tx_empty),
        .tx_byte   (tx_head),
        .tx_take   (tx_take),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .busy      (busy),
        .sck       (sck),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .miso      (miso)
    );

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = REG_W'(ctrl);
            A_RXD:   bus_rdata = REG_W'(rx_head);
            A_STAT:  bus_rdata = REG_W'({ovr_q, tc, rx_full, rx_empty, tx_full, tx_empty});
            default: bus_rdata = '0;
        endcase
    end

    assign irq_tc  = tc && ctrl.tc_ie;
    assign irq_ovr = ovr_q && ctrl.ovr_ie;
    assign dreq_tx = !ctrl.fifo_en && !tx_full;
    assign dreq_rx = !ctrl.fifo_en && !rx_empty;

    // R8: the overrun flag only falls through a status clear write
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !ovr_clr) |=> ovr_q);
endmodule

// File: tb/spim_ctl_tb.sv
`timescale 1ns/1ps
module spim_ctl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        sck, mosi, cs_n, irq_tc, irq_ovr, dreq_tx, dreq_rx;
    logic        miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // slave model state
    logic [7:0] sbyte = 8'h00;
    logic [2:0] bpos = 3'd0;
    logic [7:0] capw = 8'h00;
    int         rises = 0;
    int         cs_rises = 0;
    longint     last_rise = 0;
    int         ivl_min = 9999, ivl_max = 0;

    // {lsb_first, tx byte, slave byte}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 8'h3C, 8'hC3},
        {1'b1, 8'h3C, 8'h81},
        {1'b0, 8'h01, 8'h80},
        {1'b1, 8'h01, 8'hF0},
        {1'b1, 8'hB4, 8'h0F},
        {1'b0, 8'hFF, 8'h00}
    };

    spim_ctl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso),
        .irq_tc(irq_tc), .irq_ovr(irq_ovr), .dreq_tx(dreq_tx), .dreq_rx(dreq_rx)
    );

    always #10 clk = ~clk;

    always @(posedge sck) begin
        longint iv;
        rises = rises + 1;
        capw = {capw[6:0], mosi};
        if (last_rise != 0) begin
            iv = ($time - last_rise) / 20;
            if (int'(iv) < ivl_min) ivl_min = int'(iv);
            if (int'(iv) > ivl_max) ivl_max = int'(iv);
        end
        last_rise = $time;
        bpos = bpos + 3'd1;
        miso = sbyte[3'd7 - bpos];
    end

    always @(posedge cs_n) cs_rises = cs_rises + 1;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return r;
    endfunction

    function automatic logic [15:0] mk_ctrl(input logic [7:0] dv, input logic oie, input logic tie,
                                            input logic lvl, input logic man, input logic lsb,
                                            input logic fen);
        return {dv, 2'b00, oie, tie, lvl, man, lsb, fen};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        s = 16'h0;
        for (int g = 0; g < 20000 && !s[4]; g++) rd(2'd3, s);
    endtask

    task automatic preset(input logic [7:0] b);
        sbyte = b; bpos = 3'd0; miso = b[7];
        rises = 0; cs_rises = 0; last_rise = 0;
        ivl_min = 9999; ivl_max = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 sck", 32'(sck), 32'd0);
        chk("R10 cs_n", 32'(cs_n), 32'd1);
        chk("R10 irqs", 32'({irq_tc, irq_ovr}), 32'd0);
        chk("R10 dreq", 32'({dreq_tx, dreq_rx}), 32'b10);
        rd(2'd3, d);
        chk("R10 status", 32'(d), 32'h15);
        rd(2'd0, d);
        chk("R10 ctrl", 32'(d), 32'h0);

        // R4/R5 vector table, buffer mode, auto chip select, divider 1
        for (int i = 0; i < 6; i++) begin
            logic       lsb;
            logic [7:0] tx, sb;
            {lsb, tx, sb} = VEC[i];
            wr(2'd0, mk_ctrl(8'd1, 1'b0, 1'b0, 1'b0, 1'b0, lsb, 1'b0));
            preset(sb);
            wr(2'd1, {8'h00, tx});
            wait_idle();
            chk("R4 mosi order", 32'(capw), 32'(lsb ? rev8(tx) : tx));
            rd(2'd2, d);
            chk("R4 miso order", 32'(d[7:0]), 32'(lsb ? rev8(sb) : sb));
            chk("R5 one cs rise per frame", 32'(cs_rises), 32'd1);
            chk("R9 sck idle low", 32'(sck), 32'd0);
        end

        // R1: queue mode burst of 8, divider 2
        wr(2'd0, mk_ctrl(8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        preset(8'hA5);
        for (int i = 0; i < 8; i++) wr(2'd1, 16'(8'h10 + i));
        chk("R3 no dreq in queue mode", 32'({dreq_tx, dreq_rx}), 32'd0);
        wait_idle();
        chk("R1 burst edges", 32'(rises), 32'd64);
        chk("R5 cs held across burst", 32'(cs_rises), 32'd1);
        chk("R9 min period", 32'(ivl_min), 32'd6);
        chk("R9 max period", 32'(ivl_max), 32'd6);
        chk("R3 dreq_rx low with data queued", 32'(dreq_rx), 32'd0);
        rd(2'd3, d);
        chk("R1 rx full flag", 32'(d[3]), 32'd1);

        // R8: one more frame into a full receive queue
        wr(2'd0, mk_ctrl(8'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        wr(2'd1, 16'h005A);
        wait_idle();
        chk("R8 irq_ovr", 32'(irq_ovr), 32'd1);
        rd(2'd3, d);
        chk("R8 flag set", 32'(d[5]), 32'd1);
        rd(2'd3, d);
        chk("R8 flag sticky", 32'(d[5]), 32'd1);
        for (int i = 0; i < 8; i++) begin
            rd(2'd2, d);
            chk("R1 rx queue byte", 32'(d[7:0]), 32'hA5);
        end
        rd(2'd3, d);
        chk("R8 extra byte discarded", 32'(d[2]), 32'd1);
        wr(2'd3, 16'h0020);
        @(negedge clk);
        chk("R8 cleared", 32'(irq_ovr), 32'd0);

        // R2/R3: buffer mode, divider 3
        wr(2'd0, mk_ctrl(8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        chk("R3 dreq in buffer mode", 32'({dreq_tx, dreq_rx}), 32'b10);
        preset(8'h66);
        wr(2'd1, 16'h0011);
        repeat (2) @(negedge clk);
        wr(2'd1, 16'h0022);
        chk("R3 dreq_tx low when buffer held", 32'(dreq_tx), 32'd0);
        rd(2'd3, d);
        chk("R2 tx buffer full", 32'(d[1]), 32'd1);
        wr(2'd1, 16'h0033);
        wait_idle();
        chk("R2 third write dropped", 32'(rises), 32'd16);
        chk("R2 last frame sent", 32'(capw), 32'h22);
        chk("R3 dreq_rx with byte waiting", 32'(dreq_rx), 32'd1);
        rd(2'd3, d);
        chk("R8 overrun in buffer mode", 32'(d[5]), 32'd1);
        chk("R8 irq masked", 32'(irq_ovr), 32'd0);
        rd(2'd2, d);
        chk("R2 first rx byte", 32'(d[7:0]), 32'h66);
        @(negedge clk);
        chk("R3 dreq_rx after read", 32'(dreq_rx), 32'd0);
        wr(2'd3, 16'h0020);

        // R6: manual chip select
        wr(2'd0, mk_ctrl(8'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
        preset(8'h00);
        wr(2'd1, 16'h00C0);
        repeat (6) @(negedge clk);
        chk("R6 cs high mid frame", 32'(cs_n), 32'd1);
        wait_idle();
        chk("R6 no cs edge", 32'(cs_rises), 32'd0);
        rd(2'd2, d);
        wr(2'd0, mk_ctrl(8'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        @(negedge clk);
        chk("R6 cs low when idle", 32'(cs_n), 32'd0);

        // R7: transfer complete
        wr(2'd0, mk_ctrl(8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        chk("R7 disabled", 32'(irq_tc), 32'd0);
        wr(2'd0, mk_ctrl(8'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        chk("R7 idle high", 32'(irq_tc), 32'd1);
        wr(2'd1, 16'h0077);
        chk("R7 low while busy", 32'(irq_tc), 32'd0);
        wait_idle();
        chk("R7 high after frame", 32'(irq_tc), 32'd1);

        summary();
    end
endmodule